// File: doc/BRIEF.md
# Time-Paced GPIO Output Queue

This block drives a bank of output pins from a short queue of pending words. A writer offers whole pin words through a valid/ready port. Each accepted word waits in the queue until the next pacing tick, and then all pin bits take the new value together. The pacing tick comes from a down-counter reloaded from a programmable divider value, so pin edges fall on a fixed grid of system-clock cycles. Software can therefore pre-load a short run of pin patterns and rely on their exact spacing.

The pin inputs can be read in two ways. The immediate read port shows the present input pins without delay. When paced reading is enabled, the input pins are captured on each tick instead, and the captured word is shown with a one-cycle valid pulse.

Top module: `paced_pin_queue`

## Requirements
- R1: While `rstN` is low at a clock edge, the block resets synchronously. After reset, `pinOut` is RESET_PINS (all zero by default), `wrReady` is 1, `pacedRdValid` is 0 and the queue is empty.
- R2: A tick occurs once every `divCount`+1 clock cycles. The counter is loaded from `divCount` during reset and again on each tick. The first tick after reset therefore falls on the cycle that follows the `divCount`-th clock edge. A new `divCount` value takes effect at the next reload. A value of 0 gives a tick on every cycle.
- R3: The queue holds at most DEPTH words (4 by default). `wrReady` is 0 exactly when DEPTH words are pending. A word is accepted on a clock edge where both `wrValid` and `wrReady` are 1.
- R4: A word that is offered while the queue is full is not lost. It is accepted on the first edge after space frees up, as long as the writer keeps offering it.
- R5: On each tick with a non-empty queue, only the oldest word is removed. That word is loaded into all PIN_W bits of `pinOut` at once, on the same edge. Words reach the pins in the order they were accepted.
- R6: A tick with an empty queue leaves `pinOut` unchanged. Between ticks, `pinOut` never changes.
- R7: `immRdData` equals `pinIn` in the same cycle, with no register in the path.
- R8: If `paceRdEn` is 1 on a tick, `pinIn` is captured at that tick edge. In the next cycle, `pacedRdData` shows the captured value and `pacedRdValid` is 1. If `paceRdEn` is 0 on a tick, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| divCount | input | DIV_W | Tick period minus one, in clock cycles |
| wrValid | input | 1 | Writer offers a word |
| wrData | input | PIN_W | Word to be placed on the pins |
| wrReady | output | 1 | Queue has space |
| pinOut | output | PIN_W | Output pin levels |
| pinIn | input | PIN_W | Input pin levels |
| immRdData | output | PIN_W | Present input pin levels |
| paceRdEn | input | 1 | Capture input pins on each tick |
| pacedRdValid | output | 1 | One-cycle pulse after a captured tick |
| pacedRdData | output | PIN_W | Input pins as captured on the tick |

## Verification
The bench fills the queue while the divider is long, then offers a fifth word. A design that took that word would either drop it or overwrite the oldest entry, and the sequence of pin words would come out short or out of order. The bench times the gap between two pin updates after a change to the divider. An off-by-one in the reload, or a divider change applied at once, shows up as a gap other than `divCount`+1. It also drains the queue and waits across several empty ticks, which exposes a design that reapplies stale storage to the pins. Finally, it toggles paced reads, which catches a valid pulse that lands on the tick cycle itself, one that carries the wrong sample, or one that fires while paced reading is disabled.

// File: rtl/ppq_pkg.sv
package ppq_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic tick;    // pacing instant
    logic push;    // accept the offered word
    logic pop;     // move the oldest word to the pins
    logic sample;  // capture the input pins
  } ppqStrobe_t;
endpackage

// File: rtl/ppq_ctrl.sv
module ppq_ctrl
  import ppq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divCount,
  input  logic             wrValid,
  input  logic             paceRdEn,
  output logic             wrReady,
  output logic [OCC_W-1:0] occ,
  output ppqStrobe_t       strobe
);
  localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(DEPTH);

  logic [DIV_W-1:0] cnt;
  logic             tick;
  logic             push;
  logic             pop;

  // Tick generator: counts down and reloads on zero
  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= divCount;
    end else if (tick) begin
      cnt <= divCount;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // Occupancy and handshake
  assign wrReady = (occ < FULL_LVL);
  assign push    = wrValid && wrReady;
  assign pop     = tick && (occ != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ <= '0;
    end else begin
      unique case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_comb begin
    strobe.tick   = tick;
    strobe.push   = push;
    strobe.pop    = pop;
    strobe.sample = tick && paceRdEn;
  end
endmodule

// File: rtl/ppq_datapath.sv
module ppq_datapath
  import ppq_pkg::*;
#(
  parameter int              DEPTH      = 4,
  parameter int              PIN_W      = 32,
  parameter logic [PIN_W-1:0] RESET_PINS = '0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppqStrobe_t       strobe,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] immRdData,
  output logic             pacedRdValid,
  output logic [PIN_W-1:0] pacedRdData
);
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PIN_W-1:0] slotWord [DEPTH];
  logic [PIN_W-1:0] headWord;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // Ring pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bumpPtr(wrPtr);
      if (strobe.pop)  rdPtr <= bumpPtr(rdPtr);
    end
  end

  // One register per slot, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [PIN_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.push && (wrPtr == PTR_W'(g))) begin
        slotQ <= wrData;
      end
    end
    assign slotWord[g] = slotQ;
  end

  assign headWord = slotWord[rdPtr];

  // Output pins: all bits updated on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinOut <= RESET_PINS;
    end else if (strobe.pop) begin
      pinOut <= headWord;
    end
  end

  // Read paths
  assign immRdData = pinIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pacedRdValid <= 1'b0;
      pacedRdData  <= '0;
    end else begin
      pacedRdValid <= strobe.sample;
      if (strobe.sample) pacedRdData <= pinIn;
    end
  end
endmodule

// File: rtl/paced_pin_queue.sv
module paced_pin_queue
  import ppq_pkg::*;
#(
  parameter int               PIN_W      = 32,
  parameter int               DEPTH      = 4,
  parameter int               DIV_W      = 8,
  parameter logic [PIN_W-1:0] RESET_PINS = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divCount,
  input  logic             wrValid,
  input  logic [PIN_W-1:0] wrData,
  output logic             wrReady,
  output logic [PIN_W-1:0] pinOut,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] immRdData,
  input  logic             paceRdEn,
  output logic             pacedRdValid,
  output logic [PIN_W-1:0] pacedRdData
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  ppqStrobe_t       strobe;
  logic [OCC_W-1:0] occ;

  ppq_ctrl #(
    .DEPTH(DEPTH),
    .DIV_W(DIV_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .divCount (divCount),
    .wrValid  (wrValid),
    .paceRdEn (paceRdEn),
    .wrReady  (wrReady),
    .occ      (occ),
    .strobe   (strobe)
  );

  ppq_datapath #(
    .DEPTH     (DEPTH),
    .PIN_W     (PIN_W),
    .RESET_PINS(RESET_PINS)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .pinIn        (pinIn),
    .pinOut       (pinOut),
    .immRdData    (immRdData),
    .pacedRdValid (pacedRdValid),
    .pacedRdData  (pacedRdData)
  );
endmodule

// File: rtl/ppq_checker.sv
module ppq_checker #(
  parameter int DEPTH = 4,
  parameter int PIN_W = 32,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             pop,
  input logic [OCC_W-1:0] occ,
  input logic [PIN_W-1:0] pinOut,
  input logic [PIN_W-1:0] pinIn,
  input logic             paceRdEn,
  input logic             pacedRdValid,
  input logic [PIN_W-1:0] pacedRdData
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH)); // R3

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pop |=> $stable(pinOut)); // R6

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    pacedRdValid |-> $past(tick && paceRdEn)); // R8

  AST_SAMPLE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    pacedRdValid |-> (pacedRdData == $past(pinIn))); // R8
endmodule

bind paced_pin_queue ppq_checker #(
  .DEPTH(DEPTH),
  .PIN_W(PIN_W),
  .OCC_W(OCC_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .tick         (strobe.tick),
  .pop          (strobe.pop),
  .occ          (occ),
  .pinOut       (pinOut),
  .pinIn        (pinIn),
  .paceRdEn     (paceRdEn),
  .pacedRdValid (pacedRdValid),
  .pacedRdData  (pacedRdData)
);

// File: tb/paced_pin_queue_tb_top.sv
module paced_pin_queue_tb_top;
  localparam int PIN_W = 32;
  localparam int DEPTH = 4;
  localparam int DIV_W = 8;
  localparam int NVEC  = 8;
  // {divider, word}
  localparam logic [DIV_W+PIN_W-1:0] VEC [NVEC] = '{
    {8'd0, 32'h1111_0001}, {8'd0, 32'h2222_0002}, {8'd1, 32'h3333_0003},
    {8'd2, 32'h4444_0004}, {8'd0, 32'h5555_0005}, {8'd5, 32'hA5A5_0006},
    {8'd1, 32'h0F0F_0007}, {8'd0, 32'hFFFF_FFFF}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic [DIV_W-1:0] divCount;
  logic             wrValid;
  logic [PIN_W-1:0] wrData;
  logic             wrReady;
  logic [PIN_W-1:0] pinOut;
  logic [PIN_W-1:0] pinIn;
  logic [PIN_W-1:0] immRdData;
  logic             paceRdEn;
  logic             pacedRdValid;
  logic [PIN_W-1:0] pacedRdData;

  int  errors = 0;
  int  checks = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  paced_pin_queue #(.PIN_W(PIN_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .divCount(divCount), .wrValid(wrValid),
    .wrData(wrData), .wrReady(wrReady), .pinOut(pinOut), .pinIn(pinIn),
    .immRdData(immRdData), .paceRdEn(paceRdEn), .pacedRdValid(pacedRdValid),
    .pacedRdData(pacedRdData)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [PIN_W-1:0] act, input logic [PIN_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  logic [PIN_W-1:0] mQ [DEPTH];
  int               mOcc;
  logic [DIV_W-1:0] mCnt;
  logic [PIN_W-1:0] mPins;
  logic [PIN_W-1:0] mData;
  bit               mVal;

  always @(posedge clk) begin : mdl
    bit tk;
    bit acc;
    cyc++;
    if (!rstN) begin
      mCnt = divCount; mOcc = 0; mPins = '0; mVal = 1'b0; mData = '0;
    end else begin
      tk   = (mCnt == '0);
      acc  = wrValid && (mOcc < DEPTH);
      mVal = tk && paceRdEn;
      if (mVal) mData = pinIn;
      if (tk) mCnt = divCount; else mCnt = mCnt - 1'b1;
      if (tk && mOcc > 0) begin
        mPins = mQ[0];
        for (int i = 0; i < DEPTH - 1; i++) mQ[i] = mQ[i+1];
        mOcc--;
      end
      if (acc) begin mQ[mOcc] = wrData; mOcc++; end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN === 1'b1 && !done) begin
      check(pinOut === mPins, "R5 pins follow queue", pinOut, mPins);
      check(wrReady === (mOcc < DEPTH), "R3 ready", {31'b0, wrReady}, {31'b0, mOcc < DEPTH});
      check(pacedRdValid === mVal, "R8 paced valid", {31'b0, pacedRdValid}, {31'b0, mVal});
      if (mVal) check(pacedRdData === mData, "R8 paced data", pacedRdData, mData);
      check(immRdData === pinIn, "R7 immediate read", immRdData, pinIn);
    end
  end

  // Offer a word and hold it until accepted (R4)
  task automatic pushWord(input logic [PIN_W-1:0] w);
    bit rdy;
    wrValid = 1'b1;
    wrData  = w;
    forever begin
      rdy = wrReady;
      @(negedge clk);
      if (rdy) break;
    end
    wrValid = 1'b0;
  endtask

  // Wait for the next change on pinOut, return cycle stamp
  task automatic waitPinChange(output int stamp, output bit seen);
    logic [PIN_W-1:0] prev;
    prev = pinOut;
    seen = 1'b0;
    stamp = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); #1;
      if (pinOut !== prev) begin seen = 1'b1; stamp = cyc; break; end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(pinOut === '0, "R1 reset pins", pinOut, '0);
    check(wrReady === 1'b1, "R1 reset ready", {31'b0, wrReady}, 32'd1);
    check(pacedRdValid === 1'b0, "R1 reset valid", {31'b0, pacedRdValid}, 32'd0);
  endtask

  initial begin : stim
    logic [PIN_W-1:0] seq [5];
    int t1, t2;
    bit s1, s2;
    rstN = 1'b0; divCount = 8'd20; wrValid = 1'b0; wrData = '0;
    pinIn = 32'hC0DE_0000; paceRdEn = 1'b0;
    seq = '{32'hDEAD_0001, 32'hBEEF_0002, 32'h1234_0003, 32'h8000_0004, 32'h0000_00F5};

    // R1: reset state
    doReset();

    // R3: fill the queue while the divider is long
    for (int i = 0; i < DEPTH; i++) begin
      wrValid = 1'b1; wrData = seq[i];
      @(negedge clk);
    end
    wrValid = 1'b0;
    #1;
    check(wrReady === 1'b0, "R3 full drops ready", {31'b0, wrReady}, 32'd0);
    check(pinOut === '0, "R6 pins untouched before first tick", pinOut, '0);

    // R4: fifth word stalls, then enters; R5: order and pacing
    fork
      pushWord(seq[4]);
      begin
        for (int k = 0; k < 5; k++) begin
          waitPinChange(t1, s1);
          check(s1 && pinOut === seq[k], k == 4 ? "R4 stalled word arrives" : "R5 order",
                pinOut, seq[k]);
        end
      end
    join

    // R2: spacing after a divider change takes effect on reload
    divCount = 8'd3;
    @(negedge clk);
    pushWord(32'hAAAA_5555);
    pushWord(32'h5555_AAAA);
    waitPinChange(t1, s1);
    waitPinChange(t2, s2);
    check(s1 && s2 && (t2 - t1) == 4, "R2 tick spacing", 32'(t2 - t1), 32'd4);

    // R6: empty ticks leave pins alone
    repeat (12) @(negedge clk);
    #1;
    check(pinOut === 32'h5555_AAAA, "R6 hold on empty", pinOut, 32'h5555_AAAA);

    // R8: paced read on, then off
    paceRdEn = 1'b1; pinIn = 32'h1234_5678;
    s1 = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (pacedRdValid) begin s1 = 1'b1; break; end
    end
    check(s1 && pacedRdData === 32'h1234_5678, "R8 paced sample", pacedRdData, 32'h1234_5678);
    paceRdEn = 1'b0;
    @(negedge clk); #1;
    s2 = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      if (pacedRdValid) s2 = 1'b1;
    end
    check(!s2, "R8 no pulse when disabled", {31'b0, s2}, 32'd0);

    // Vector table: divider, pin input pattern and read mode per word
    for (int i = 0; i < NVEC; i++) begin
      divCount = VEC[i][DIV_W+PIN_W-1:PIN_W];
      pinIn    = ~VEC[i][PIN_W-1:0];
      paceRdEn = i[0];
      pushWord(VEC[i][PIN_W-1:0]);
    end
    repeat (60) @(negedge clk);
    #1;
    check(pinOut === 32'hFFFF_FFFF, "R5 last vector on pins", pinOut, 32'hFFFF_FFFF);

    // R1: reset with a loaded queue empties it
    divCount = 8'd30;
    pushWord(32'h0101_0101);
    pushWord(32'h0202_0202);
    doReset();
    repeat (40) @(negedge clk);
    #1;
    check(pinOut === '0, "R1 queue cleared by reset", pinOut, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule